// File: doc/BRIEF.md
# Non-volatile Data Array Fill Controller

This block sits between a processor's register interface and a 512-byte non-volatile data array, which is modelled here as a plain synchronous memory. It accepts four commands: read one byte, program one byte, fill one 64-byte row with a single value, and fill the whole array with a single value. Writing the value 00h with either fill command erases that region. Every program step takes a fixed, parameter-set number of clock cycles, and the fills step through their addresses one byte per program interval.

When a program or fill command finishes, the controller raises a sticky completion flag. The flag can drive an interrupt line, and software clears it. A supply brownout input locks out programming. A command issued while the input is high is refused. A fill that is running when the input rises is cut short. In both cases two error bits are set. They stay set until power-on reset, a watchdog reset pulse or a software clear.

Top module: `nvfill_top`

## Requirements
- R1: After power-on reset (rstN low), busy, doneFlag, irq and errFlags are all 0.
- R2: A command with cmdOp = 2'b00 while idle returns the byte at cmdAddr on rdData one cycle after the request. It does not set doneFlag and does not raise busy.
- R3: A command with cmdOp = 2'b01 while idle stores cmdData at cmdAddr. busy is high for exactly WR_CYCLES cycles after the accepting edge.
- R4: A command with cmdOp = 2'b10 writes cmdData into all 64 bytes of the row selected by cmdAddr[8:6], ignoring cmdAddr[5:0], and leaves every other row unchanged. busy lasts 64*WR_CYCLES cycles.
- R5: A command with cmdOp = 2'b11 writes cmdData into all 512 bytes. Filling with 00h erases the array.
- R6: A command presented while busy is high is ignored and changes no byte of the array.
- R7: doneFlag is set on the same edge at which busy falls after a write or fill completes. It then stays set until a doneClr pulse.
- R8: irq is high exactly when doneFlag and irqEn are both high.
- R9: A write or fill command issued while brownout is high is not performed. busy stays low, doneFlag is not set and errFlags becomes 2'b11.
- R10: If brownout rises during a write or fill, no further byte is written and busy falls on the next edge. errFlags becomes 2'b11 and doneFlag is not set.
- R11: errFlags holds its value until rstN, a wdogRst pulse or an errClr pulse clears it to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| wdogRst | input | 1 | Synchronous watchdog reset pulse; clears the error bits |
| cmdValid | input | 1 | Command request strobe |
| cmdOp | input | 2 | 00 read, 01 byte write, 10 row fill, 11 array fill |
| cmdAddr | input | 9 | Byte address; bits [8:6] select the row for a row fill |
| cmdData | input | 8 | Byte to write or fill value |
| irqEn | input | 1 | Interrupt enable |
| doneClr | input | 1 | Software clear of the completion flag |
| errClr | input | 1 | Software clear of the error bits |
| brownout | input | 1 | Supply-low lockout; blocks program and fill |
| rdData | output | 8 | Read result, valid the cycle after a read request |
| busy | output | 1 | A write or fill is in progress |
| doneFlag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| errFlags | output | 2 | Sticky write-error bits |

## Verification
The bound checker watches, on every cycle, the relations that are visible at the ports. These are the stickiness of the completion and error flags, the alignment of a rising doneFlag with a falling busy, the interrupt gating, the refusal of commands under brownout, the silence of reads toward doneFlag, and the start of busy for an accepted program command. Only the bench's scenarios can show what ended up in the array. That covers row isolation and cmdAddr[5:0] being ignored, the full-array fill and erase, the exact length of each busy window, the survival of earlier bytes after a fill aborted by brownout, and the absence of any effect from commands issued while busy.

// File: rtl/nvfill_pkg.sv
package nvfill_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'b00,
    OP_BYTE = 2'b01,
    OP_ROW  = 2'b10,
    OP_ALL  = 2'b11
  } nvOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  loadAddr;  // capture start address, value and mode
    logic  memWe;     // write the latched value at the current address
    logic  incAddr;   // step to the next address of a fill
    logic  rdEn;      // register a read of cmdAddr
    nvOp_e mode;      // mode to latch with loadAddr
  } dpStrobe_t;

endpackage

// File: rtl/nvfill_dpath.sv
module nvfill_dpath
  import nvfill_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int ROW_BITS = 6,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              lastAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int ROW_HI = ADDR_W - ROW_BITS;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] fillVal;
  nvOp_e             curMode;
  logic [ADDR_W-1:0] startAddr;

  // Start address depends on the command kind
  always_comb begin
    unique case (strobe.mode)
      OP_ROW:  startAddr = {cmdAddr[ADDR_W-1 -: ROW_HI], {ROW_BITS{1'b0}}};
      OP_ALL:  startAddr = '0;
      default: startAddr = cmdAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      fillVal <= '0;
      curMode <= OP_READ;
    end else if (strobe.loadAddr) begin
      curAddr <= startAddr;
      fillVal <= cmdData;
      curMode <= strobe.mode;
    end else if (strobe.incAddr) begin
      curAddr <= curAddr + 1'b1;
    end
  end

  // Final address of the running operation
  always_comb begin
    unique case (curMode)
      OP_ROW:  lastAddr = &curAddr[ROW_BITS-1:0];
      OP_ALL:  lastAddr = &curAddr;
      default: lastAddr = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.memWe) mem[curAddr] <= fillVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.rdEn)  rdData <= mem[cmdAddr];
  end

endmodule

// File: rtl/nvfill_ctrl.sv
module nvfill_ctrl
  import nvfill_pkg::*;
#(
  parameter int WR_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdogRst,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       brownout,
  input  logic       doneClr,
  input  logic       errClr,
  input  logic       lastAddr,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       doneFlag,
  output logic [1:0] errFlags
);
  localparam int TMR_W = $clog2(WR_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WR_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_PROG} state_e;

  state_e           state;
  logic [TMR_W-1:0] timer;
  logic             accept;
  logic             isProg;
  logic             startProg;
  logic             blocked;
  logic             tick;
  logic             finish;
  logic             abortOp;

  assign accept    = cmdValid && (state == ST_IDLE);
  assign isProg    = nvOp_e'(cmdOp) != OP_READ;
  assign startProg = accept && isProg && !brownout;
  assign blocked   = accept && isProg && brownout;
  assign tick      = (state == ST_PROG) && (timer == TMR_LAST);
  assign abortOp   = (state == ST_PROG) && brownout;
  assign finish    = tick && !brownout && lastAddr;

  always_comb begin
    strobe          = '0;
    strobe.mode     = nvOp_e'(cmdOp);
    strobe.rdEn     = accept && !isProg;
    strobe.loadAddr = startProg;
    strobe.memWe    = tick && !brownout;
    strobe.incAddr  = tick && !brownout && !lastAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          timer <= '0;
          if (startProg) state <= ST_PROG;
        end
        ST_PROG: begin
          if (abortOp || finish) begin
            state <= ST_IDLE;
            timer <= '0;
          end else if (tick) begin
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         doneFlag <= 1'b0;
    else if (finish)   doneFlag <= 1'b1;
    else if (doneClr)  doneFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    errFlags <= 2'b00;
    else if (blocked || abortOp)  errFlags <= 2'b11;
    else if (errClr || wdogRst)   errFlags <= 2'b00;
  end

  assign busy = (state == ST_PROG);

endmodule

// File: rtl/nvfill_top.sv
module nvfill_top
  import nvfill_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int ROW_BITS  = 6,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wdogRst,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              irqEn,
  input  logic              doneClr,
  input  logic              errClr,
  input  logic              brownout,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              doneFlag,
  output logic              irq,
  output logic [1:0]        errFlags
);
  dpStrobe_t strobe;
  logic      lastAddr;

  nvfill_ctrl #(.WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wdogRst  (wdogRst),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .brownout (brownout),
    .doneClr  (doneClr),
    .errClr   (errClr),
    .lastAddr (lastAddr),
    .strobe   (strobe),
    .busy     (busy),
    .doneFlag (doneFlag),
    .errFlags (errFlags)
  );

  nvfill_dpath #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .lastAddr (lastAddr),
    .rdData   (rdData)
  );

  assign irq = doneFlag && irqEn;

endmodule

// File: rtl/nvfill_checker.sv
module nvfill_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wdogRst,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       irqEn,
  input logic       doneClr,
  input logic       errClr,
  input logic       brownout,
  input logic       busy,
  input logic       doneFlag,
  input logic       irq,
  input logic [1:0] errFlags
);

  // R7: the flag rises only as an operation ends
  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $fell(busy));

  // R7: the flag holds without a clear
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !doneClr |=> doneFlag);

  // R8: the interrupt follows the flag and the enable
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq == (doneFlag && irqEn));

  // R9: a refused command sets the errors and starts nothing
  p_blocked_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !busy && brownout && cmdOp != 2'b00 |=> !busy && errFlags == 2'b11);

  // R10: brownout ends a running operation
  p_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && brownout |=> !busy && errFlags == 2'b11 && !$rose(doneFlag));

  // R11: the errors hold without a clear
  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !errClr && !wdogRst |=> errFlags == 2'b11 || $stable(errFlags));

  // R2: a read never raises busy or the flag
  p_read_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !busy && cmdOp == 2'b00 && !doneFlag |=> !busy && !doneFlag);

  // R3: an accepted program command raises busy
  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !busy && !brownout && cmdOp != 2'b00 |=> busy);

endmodule

bind nvfill_top nvfill_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wdogRst  (wdogRst),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .irqEn    (irqEn),
  .doneClr  (doneClr),
  .errClr   (errClr),
  .brownout (brownout),
  .busy     (busy),
  .doneFlag (doneFlag),
  .irq      (irq),
  .errFlags (errFlags)
);

// File: tb/nvfill_top_bench.sv
module nvfill_top_bench;
  localparam int WR = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wdogRst = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [8:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic       irqEn = 1'b0;
  logic       doneClr = 1'b0;
  logic       errClr = 1'b0;
  logic       brownout = 1'b0;
  logic [7:0] rdData;
  logic       busy, doneFlag, irq;
  logic [1:0] errFlags;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] model [512];

  always #2 clk = ~clk;

  nvfill_top #(.WR_CYCLES(WR)) u_nvfill_top (
    .clk(clk), .rstN(rstN), .wdogRst(wdogRst), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData), .irqEn(irqEn),
    .doneClr(doneClr), .errClr(errClr), .brownout(brownout),
    .rdData(rdData), .busy(busy), .doneFlag(doneFlag), .irq(irq),
    .errFlags(errFlags)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one command for a single cycle; returns at the negedge after acceptance
  task automatic issue(input logic [1:0] op, input logic [8:0] a, input logic [7:0] d);
    cmdOp = op; cmdAddr = a; cmdData = d; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle(output int cycles);
    cycles = 0;
    while (busy && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic clearDone();
    doneClr = 1'b1; @(negedge clk); doneClr = 1'b0;
  endtask

  task automatic readByte(input logic [8:0] a, output logic [7:0] v);
    issue(2'b00, a, 8'h00);
    v = rdData;
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(doneFlag == 1'b0, "R1 doneFlag", doneFlag, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(errFlags == 2'b00, "R1 errFlags", errFlags, 0);
  endtask

  task automatic t_array_fill(input logic [7:0] v, input string req);
    int n;
    logic [7:0] r;
    int bad = 0;
    int firstBad = 0;
    issue(2'b11, 9'd77, v);
    waitIdle(n);
    chk(n == 512 * WR, {req, " array fill duration"}, n, 512 * WR);
    for (int i = 0; i < 512; i++) model[i] = v;
    for (int i = 0; i < 512; i++) begin
      readByte(9'(i), r);
      if (r != v && bad == 0) firstBad = int'(r);
      if (r != v) bad++;
    end
    chk(bad == 0, {req, " array contents"}, firstBad, int'(v));
    clearDone();
  endtask

  task automatic t_byte_rw();
    int n;
    logic [7:0] r;
    irqEn = 1'b1;
    issue(2'b01, 9'd300, 8'h5A);
    chk(busy == 1'b1, "R3 busy after accept", busy, 1);
    waitIdle(n);
    chk(n == WR, "R3 busy length", n, WR);
    chk(doneFlag == 1'b1, "R7 done at busy fall", doneFlag, 1);
    chk(irq == 1'b1, "R8 irq enabled", irq, 1);
    model[300] = 8'h5A;
    repeat (3) @(negedge clk);
    chk(doneFlag == 1'b1, "R7 done sticky", doneFlag, 1);
    irqEn = 1'b0;
    #0;
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    clearDone();
    chk(doneFlag == 1'b0, "R7 done cleared", doneFlag, 0);
    readByte(9'd300, r);
    chk(r == 8'h5A, "R3 byte stored", r, 8'h5A);
    chk(doneFlag == 1'b0 && busy == 1'b0, "R2 read sets no done", doneFlag, 0);
    readByte(9'd301, r);
    chk(r == model[301], "R2 neighbour read", r, model[301]);
  endtask

  task automatic t_row_fill(input logic [7:0] v, input string req);
    int n;
    logic [7:0] r;
    int bad = 0;
    model[127] = 8'h11; model[192] = 8'h22;
    issue(2'b01, 9'd127, 8'h11); waitIdle(n); clearDone();
    issue(2'b01, 9'd192, 8'h22); waitIdle(n); clearDone();
    issue(2'b10, 9'd133, v);   // row 2, low bits nonzero
    waitIdle(n);
    chk(n == 64 * WR, {req, " row fill duration"}, n, 64 * WR);
    chk(doneFlag == 1'b1, "R7 done after row fill", doneFlag, 1);
    clearDone();
    for (int i = 128; i < 192; i++) model[i] = v;
    for (int i = 0; i < 512; i++) begin
      readByte(9'(i), r);
      if (r != model[i]) bad++;
    end
    chk(bad == 0, {req, " row contents and isolation"}, bad, 0);
  endtask

  task automatic t_busy_ignore();
    int n;
    logic [7:0] r;
    issue(2'b10, 9'd0, 8'hC3);
    repeat (5) @(negedge clk);
    issue(2'b01, 9'd400, 8'hEE);   // during busy
    issue(2'b11, 9'd0, 8'h99);     // during busy
    waitIdle(n);
    chk(n == 64 * WR - 7, "R6 fill length unaffected", n, 64 * WR - 7);
    for (int i = 0; i < 64; i++) model[i] = 8'hC3;
    clearDone();
    readByte(9'd400, r);
    chk(r == model[400], "R6 ignored write", r, model[400]);
    readByte(9'd70, r);
    chk(r == model[70], "R6 ignored fill", r, model[70]);
  endtask

  task automatic t_brownout_block();
    logic [7:0] r;
    brownout = 1'b1;
    issue(2'b01, 9'd10, 8'h77);
    chk(busy == 1'b0, "R9 no busy", busy, 0);
    chk(errFlags == 2'b11, "R9 errFlags", errFlags, 3);
    @(negedge clk);
    chk(doneFlag == 1'b0, "R9 no done", doneFlag, 0);
    brownout = 1'b0;
    readByte(9'd10, r);
    chk(r == model[10], "R9 byte not written", r, model[10]);
    repeat (2) @(negedge clk);
    chk(errFlags == 2'b11, "R11 errors hold", errFlags, 3);
    errClr = 1'b1; @(negedge clk); errClr = 1'b0;
    chk(errFlags == 2'b00, "R11 errClr clears", errFlags, 0);
  endtask

  task automatic t_brownout_abort();
    int n;
    logic [7:0] r;
    issue(2'b10, 9'd448, 8'h3C);   // row 7
    repeat (3 * WR) @(negedge clk);
    brownout = 1'b1;
    @(negedge clk);
    brownout = 1'b0;
    chk(busy == 1'b0, "R10 busy ends", busy, 0);
    chk(errFlags == 2'b11, "R10 errFlags", errFlags, 3);
    chk(doneFlag == 1'b0, "R10 no done", doneFlag, 0);
    waitIdle(n);
    readByte(9'd448, r);
    chk(r == 8'h3C, "R10 early byte kept", r, 8'h3C);
    readByte(9'd511, r);
    chk(r == model[511], "R10 later byte untouched", r, model[511]);
    wdogRst = 1'b1; @(negedge clk); wdogRst = 1'b0;
    chk(errFlags == 2'b00, "R11 watchdog clears", errFlags, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_array_fill(8'h00, "R5 erase");
    t_byte_rw();
    t_row_fill(8'hA5, "R4");
    t_row_fill(8'h00, "R4 erase");
    t_busy_ignore();
    t_brownout_block();
    t_brownout_abort();
    t_array_fill(8'h6B, "R5");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule